// File: doc/BRIEF.md
# Two-World Interrupt CPU Interface

This block sits between an interrupt distributor and one processor. It sees the level of each interrupt line, the priority of each interrupt and whether the interrupt belongs to the secure group (group 0) or the non-secure group (group 1). From these it picks the best candidate and drives the processor interrupt line. It also serves a small register port through which software reads the acknowledge ID, signals end of interrupt, and programs the priority mask, the binary point and a control bit. The register port carries a secure attribute with each access.

A non-secure access sees a folded view of the priority space. The lower half of the priority range, values 0x00 to 0x7F, is hidden from it. The upper half is stretched so that it appears to cover the full range. The binary point has a separate non-secure copy. That copy can be overridden by the secure one through a common-binary-point control bit. The running priority comes from the group priorities captured when each active interrupt was acknowledged. With nothing active it reads as all-ones.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset no interrupt is active and the interrupt output is low. Secure reads return the following: priority mask 0x00, binary point 2, running priority 0xFF, control 0. A read of the acknowledge register returns 1023 while no line is asserted.
- R2: The group priority of an interrupt is its 8-bit priority with bits [e:0] cleared, where e is the effective binary point. The candidate is the asserted, inactive interrupt with the numerically lowest group priority; on a tie the lowest ID wins. `irqOut` is high exactly when the candidate's group priority is strictly below both the priority mask and the running priority.
- R3: A read of the acknowledge register (address 3) returns the candidate ID and marks that interrupt active. It also records the interrupt's group priority. An active interrupt is never selected again, even if its line stays high or its group priority later falls.
- R4: When no candidate qualifies, an acknowledge read returns 1023 and changes no state.
- R5: A write of an ID to the end-of-interrupt register (address 4) clears that interrupt's active state. The running priority then falls back to the lowest recorded group priority among the interrupts still active, or to idle. IDs of 32 or more are ignored.
- R6: The running priority register (address 5) reads the lowest recorded group priority among active interrupts. With nothing active it reads 0xFF in both views.
- R7: A non-secure read of the priority mask (address 1) returns 0x00 when stored bit 7 is clear. Otherwise it returns the stored value shifted left by one, truncated to 8 bits.
- R8: A non-secure write to the priority mask is ignored while stored bit 7 is clear. Otherwise it stores the written value shifted right by one, with bit 7 set.
- R9: A non-secure read of the running priority, when something is active, applies the same fold as R7.
- R10: Control bit 0 (address 0) is the common-binary-point bit. When it is 1, a non-secure read of the binary point (address 2) returns the secure binary point plus one, saturated at 7, and a non-secure write to it is ignored. When it is 0, non-secure accesses reach the separate non-secure binary point.
- R11: Group-0 interrupts use the secure binary point as e. Group-1 interrupts use the secure binary point when the common bit is 1. Otherwise they use the non-secure binary point plus one, saturated at 7.
- R12: Addresses 6 to 15 read as zero and ignore writes. The control register can be written only by secure accesses and reads as zero to non-secure ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | 32 | Level of each interrupt line |
| irqPrio | input | 256 | Priority of interrupt i in bits [8i+7:8i] |
| irqGroup | input | 32 | 1 = interrupt i is group 1 (non-secure) |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regSecure | input | 1 | 1 = access is secure |
| regAddr | input | 4 | Register address |
| regWdata | input | 10 | Write data |
| regRdata | output | 10 | Read data, valid while regRd is high |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench raises the binary point after an acknowledge, which drops the active interrupt's group priority to zero. A design that failed to exclude active interrupts would then re-signal the interrupt it is already serving. It checks the running priority on an idle interface, where a truncated 9-bit value would read 0x00 (highest priority) instead of 0xFF. It drives non-secure mask writes both while the stored mask is in the secure range and while it is in the non-secure range, and it reads values with bit 7 both clear and set. A design with the fold inverted would leak secure values or store unmasked ones. It also sets up a group-1 interrupt whose winner depends on the plus-one binary point adjustment, so a design that left out the adjustment would acknowledge a different ID.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PMASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_BINPT = 4'd2;
  localparam logic [ADDR_W-1:0] A_ACK   = 4'd3;
  localparam logic [ADDR_W-1:0] A_EOI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_RUNPR = 4'd5;
  localparam logic [ADDR_W-1:0] A_LAST  = 4'd5;

  typedef struct packed {
    logic ctrlWr;
    logic pmaskWr;
    logic bpSecWr;
    logic bpNsWr;
    logic ack;
    logic eoi;
  } dpStrobe_t;
endpackage

// File: rtl/irq_cpu_dp.sv
module irq_cpu_dp
  import irq_cpu_pkg::*;
#(
  parameter int N   = 32,
  parameter int PW  = 8,
  parameter int IDW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    lineIn,
  input  logic [N*PW-1:0] prioIn,
  input  logic [N-1:0]    groupIn,
  input  dpStrobe_t       stb,
  input  logic [PW-1:0]   wrVal,
  input  logic [IDW-1:0]  eoiId,
  output logic [PW-1:0]   pmask,
  output logic [$clog2(PW)-1:0] bpSec,
  output logic [$clog2(PW)-1:0] bpNs,
  output logic            commonBp,
  output logic [PW:0]     runPrio,
  output logic            candValid,
  output logic [IDW-1:0]  candId
);
  localparam int BPW = $clog2(PW);
  localparam int IW  = $clog2(N);
  localparam logic [PW:0] IDLE = {1'b1, {PW{1'b0}}};
  localparam logic [BPW-1:0] BP_MAX = BPW'(PW - 1);
  localparam logic [BPW-1:0] BP_RST = BPW'(2);

  logic [N-1:0]    active;
  logic [PW-1:0]   actGp [N];
  logic [N*PW-1:0] grpFlat;
  logic [PW:0]     bestGp;
  logic [IW-1:0]   bestIdx;

  // group priority per interrupt
  for (genvar gi = 0; gi < N; gi++) begin : g_grp
    logic [BPW-1:0] bpSel;
    logic [PW:0]    keep;
    assign bpSel = (groupIn[gi] && !commonBp)
                 ? ((bpNs == BP_MAX) ? BP_MAX : bpNs + BPW'(1))
                 : bpSec;
    assign keep = {(PW+1){1'b1}} << ({1'b0, bpSel} + (BPW+1)'(1));
    assign grpFlat[gi*PW +: PW] = prioIn[gi*PW +: PW] & keep[PW-1:0];
  end

  always_comb begin
    bestGp  = IDLE;
    bestIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (lineIn[i] && !active[i] && ({1'b0, grpFlat[i*PW +: PW]} < bestGp)) begin
        bestGp  = {1'b0, grpFlat[i*PW +: PW]};
        bestIdx = IW'(i);
      end
    end
  end

  always_comb begin
    runPrio = IDLE;
    for (int i = 0; i < N; i++) begin
      if (active[i] && ({1'b0, actGp[i]} < runPrio)) runPrio = {1'b0, actGp[i]};
    end
  end

  assign candValid = !bestGp[PW] && (bestGp[PW-1:0] < pmask) && (bestGp < runPrio);
  assign candId    = IDW'(bestIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= '0;
      pmask    <= '0;
      bpSec    <= BP_RST;
      bpNs     <= BP_RST;
      commonBp <= 1'b0;
      for (int i = 0; i < N; i++) actGp[i] <= '0;
    end else begin
      if (stb.ctrlWr)  commonBp <= wrVal[0];
      if (stb.pmaskWr) pmask    <= wrVal;
      if (stb.bpSecWr) bpSec    <= wrVal[BPW-1:0];
      if (stb.bpNsWr)  bpNs     <= wrVal[BPW-1:0];
      if (stb.ack && candValid) begin
        active[bestIdx] <= 1'b1;
        actGp[bestIdx]  <= bestGp[PW-1:0];
      end
      if (stb.eoi && (eoiId < IDW'(N))) active[eoiId[IW-1:0]] <= 1'b0;
    end
  end

  AST_ACK_NOT_RESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && candValid) |=> !(candValid && candId == $past(candId))); // R3
  AST_EOI_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && eoiId < IDW'(N)) |=> !active[$past(eoiId[IW-1:0])]); // R5
  AST_IDLE_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (active == '0) |-> (runPrio == IDLE)); // R6
  AST_SIGNAL_BELOW_MASK: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> (pmask != '0)); // R2
endmodule

// File: rtl/irq_cpu_ctl.sv
module irq_cpu_ctl
  import irq_cpu_pkg::*;
#(
  parameter int PW  = 8,
  parameter int IDW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic              regSecure,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [IDW-1:0]    regWdata,
  input  logic [PW-1:0]     pmask,
  input  logic [$clog2(PW)-1:0] bpSec,
  input  logic [$clog2(PW)-1:0] bpNs,
  input  logic              commonBp,
  input  logic [PW:0]       runPrio,
  input  logic              candValid,
  input  logic [IDW-1:0]    candId,
  output dpStrobe_t         stb,
  output logic [PW-1:0]     wrVal,
  output logic [IDW-1:0]    regRdata
);
  localparam int BPW = $clog2(PW);
  localparam logic [BPW-1:0] BP_MAX = BPW'(PW - 1);
  localparam logic [IDW-1:0] SPURIOUS = IDW'(1023);

  function automatic logic [PW-1:0] nsFold(input logic [PW-1:0] v);
    return v[PW-1] ? {v[PW-2:0], 1'b0} : '0;
  endfunction

  logic [PW-1:0] runByte;
  logic [IDW-1:0] rdMux;

  always_comb begin
    stb   = '0;
    wrVal = '0;
    if (regWr) begin
      unique case (regAddr)
        A_CTRL: begin
          stb.ctrlWr = regSecure;
          wrVal      = PW'(regWdata[0]);
        end
        A_PMASK: begin
          stb.pmaskWr = regSecure || pmask[PW-1];
          wrVal       = regSecure ? regWdata[PW-1:0] : {1'b1, regWdata[PW-1:1]};
        end
        A_BINPT: begin
          stb.bpSecWr = regSecure;
          stb.bpNsWr  = !regSecure && !commonBp;
          wrVal       = PW'(regWdata[BPW-1:0]);
        end
        A_EOI:   stb.eoi = 1'b1;
        default: ;
      endcase
    end
    if (regRd && regAddr == A_ACK) stb.ack = 1'b1;
  end

  assign runByte = runPrio[PW] ? {PW{1'b1}} : runPrio[PW-1:0];

  always_comb begin
    unique case (regAddr)
      A_CTRL:  rdMux = regSecure ? IDW'(commonBp) : '0;
      A_PMASK: rdMux = IDW'(regSecure ? pmask : nsFold(pmask));
      A_BINPT: rdMux = regSecure ? IDW'(bpSec)
                     : commonBp ? IDW'((bpSec == BP_MAX) ? BP_MAX : bpSec + BPW'(1))
                     : IDW'(bpNs);
      A_ACK:   rdMux = candValid ? candId : SPURIOUS;
      A_RUNPR: rdMux = IDW'((regSecure || runPrio[PW]) ? runByte : nsFold(runByte));
      default: rdMux = '0;
    endcase
  end

  assign regRdata = regRd ? rdMux : '0;

  AST_NS_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSecure && regAddr == A_PMASK && !pmask[PW-1]) |=> $stable(pmask)); // R8
  AST_NS_MASK_TOPBIT: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSecure && regAddr == A_PMASK && pmask[PW-1]) |=> pmask[PW-1]); // R8
  AST_NS_BINPT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSecure && regAddr == A_BINPT && commonBp) |=> ($stable(bpSec) && $stable(bpNs))); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr > A_LAST) |-> (regRdata == '0)); // R12
  AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == A_RUNPR && runPrio[PW]) |-> (regRdata == IDW'({PW{1'b1}}))); // R6
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_cpu_pkg::*;
#(
  parameter int N   = 32,
  parameter int PW  = 8,
  parameter int IDW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      irqLine,
  input  logic [N*PW-1:0]   irqPrio,
  input  logic [N-1:0]      irqGroup,
  input  logic              regRd,
  input  logic              regWr,
  input  logic              regSecure,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [IDW-1:0]    regWdata,
  output logic [IDW-1:0]    regRdata,
  output logic              irqOut
);
  localparam int BPW = $clog2(PW);

  dpStrobe_t      stb;
  logic [PW-1:0]  wrVal;
  logic [PW-1:0]  pmask;
  logic [BPW-1:0] bpSec;
  logic [BPW-1:0] bpNs;
  logic           commonBp;
  logic [PW:0]    runPrio;
  logic           candValid;
  logic [IDW-1:0] candId;

  irq_cpu_ctl #(.PW(PW), .IDW(IDW)) u_ctl (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regSecure(regSecure),
    .regAddr(regAddr), .regWdata(regWdata), .pmask(pmask), .bpSec(bpSec),
    .bpNs(bpNs), .commonBp(commonBp), .runPrio(runPrio), .candValid(candValid),
    .candId(candId), .stb(stb), .wrVal(wrVal), .regRdata(regRdata)
  );

  irq_cpu_dp #(.N(N), .PW(PW), .IDW(IDW)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(irqLine), .prioIn(irqPrio), .groupIn(irqGroup),
    .stb(stb), .wrVal(wrVal), .eoiId(regWdata), .pmask(pmask), .bpSec(bpSec),
    .bpNs(bpNs), .commonBp(commonBp), .runPrio(runPrio), .candValid(candValid),
    .candId(candId)
  );

  assign irqOut = candValid;
endmodule

// File: tb/irq_cpu_port_tb.sv
module irq_cpu_port_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  irqLine = '0;
  logic [255:0] irqPrio;
  logic [31:0]  irqGroup = '0;
  logic         regRd = 1'b0, regWr = 1'b0, regSecure = 1'b1;
  logic [3:0]   regAddr = '0;
  logic [9:0]   regWdata = '0;
  logic [9:0]   regRdata;
  logic         irqOut;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  irq_cpu_port u_dut (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .irqPrio(irqPrio), .irqGroup(irqGroup),
    .regRd(regRd), .regWr(regWr), .regSecure(regSecure), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  localparam logic [3:0] CTRL = 4'd0, PMASK = 4'd1, BINPT = 4'd2, ACK = 4'd3,
                         EOI = 4'd4, RUNPR = 4'd5;
  localparam logic S = 1'b1, NS = 1'b0;

  typedef struct packed {
    logic [31:0] pend;
    logic [7:0]  pm;
    logic        expIrq;
    logic [9:0]  expId;
  } vec_t;

  // priority of id i is 0xF0 - 4*i, group priority at binary point 2 clears bits [2:0]
  localparam vec_t VECS [8] = '{
    '{32'h0000_0000, 8'hFF, 1'b0, 10'd1023},
    '{32'h0000_0001, 8'hFF, 1'b1, 10'd0},
    '{32'h0000_0001, 8'hF0, 1'b0, 10'd1023},
    '{32'h0000_0006, 8'hFF, 1'b1, 10'd1},
    '{32'h0000_0018, 8'hE8, 1'b1, 10'd3},
    '{32'h8000_0001, 8'hFF, 1'b1, 10'd31},
    '{32'h8000_0001, 8'h70, 1'b0, 10'd1023},
    '{32'h8000_0001, 8'h71, 1'b1, 10'd31}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [9:0] d, input logic sec);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d; regSecure = sec;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic sec, input int exp,
                       input string req, input string what);
    @(negedge clk);
    regRd = 1'b1; regAddr = a; regSecure = sec;
    #2 chk(req, what, int'(regRdata), exp);
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic irqChk(input int exp, input string req, input string what);
    @(negedge clk);
    #2 chk(req, what, int'(irqOut), exp);
  endtask

  task automatic setLines(input logic [31:0] v);
    @(negedge clk);
    irqLine = v;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) irqPrio[i*8 +: 8] = 8'hF0 - 8'(4 * i);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    irqChk(0, "R1", "irqOut after reset");
    rdChk(PMASK, S, 8'h00, "R1", "mask after reset");
    rdChk(BINPT, S, 2, "R1", "secure binary point");
    rdChk(BINPT, NS, 2, "R1", "non-secure binary point");
    rdChk(RUNPR, S, 8'hFF, "R1", "running priority idle");
    rdChk(CTRL, S, 0, "R1", "control");
    rdChk(ACK, S, 1023, "R1", "ack with nothing pending");

    // R2 / R4 table of selection cases
    for (int v = 0; v < 8; v++) begin
      wr(PMASK, {2'b0, VECS[v].pm}, S);
      setLines(VECS[v].pend);
      irqChk(int'(VECS[v].expIrq), "R2", $sformatf("irqOut vec %0d", v));
      rdChk(ACK, S, int'(VECS[v].expId), VECS[v].expIrq ? "R2" : "R4",
            $sformatf("ack id vec %0d", v));
      wr(EOI, VECS[v].expId, S);
      setLines('0);
    end

    // R3 active interrupt excluded even when its group priority falls
    wr(PMASK, 10'hFF, S);
    setLines(32'h0000_0008);
    rdChk(ACK, S, 3, "R3", "ack of id 3");
    rdChk(RUNPR, S, 8'hE0, "R6", "running after ack");
    rdChk(RUNPR, NS, 8'hC0, "R9", "non-secure running folded");
    irqChk(0, "R3", "irqOut with only active line");
    wr(BINPT, 7, S);
    irqChk(0, "R3", "irqOut after binary point raise");
    rdChk(ACK, S, 1023, "R3", "active not reselected");
    rdChk(RUNPR, S, 8'hE0, "R3", "running uses recorded priority");
    wr(EOI, 3, S);
    rdChk(RUNPR, S, 8'hFF, "R6", "idle after eoi secure");
    rdChk(RUNPR, NS, 8'hFF, "R6", "idle after eoi non-secure");
    irqChk(1, "R5", "line signals again after eoi");
    wr(BINPT, 2, S);
    setLines('0);

    // R5 nesting
    setLines(32'h0000_0001);
    rdChk(ACK, S, 0, "R5", "ack id 0");
    setLines(32'h0000_0009);
    irqChk(1, "R2", "preemption by higher priority");
    rdChk(ACK, S, 3, "R5", "nested ack id 3");
    rdChk(RUNPR, S, 8'hE0, "R5", "running nested");
    wr(EOI, 3, S);
    rdChk(RUNPR, S, 8'hF0, "R5", "running back to outer");
    wr(EOI, 0, S);
    rdChk(RUNPR, S, 8'hFF, "R5", "running idle");
    wr(EOI, 10'd40, S);
    rdChk(RUNPR, S, 8'hFF, "R5", "out of range eoi ignored");
    setLines('0);

    // R9 secure-range running priority hidden from non-secure
    setLines(32'h8000_0000);
    rdChk(ACK, S, 31, "R9", "ack id 31");
    rdChk(RUNPR, NS, 8'h00, "R9", "non-secure sees zero");
    rdChk(RUNPR, S, 8'h70, "R6", "secure running 0x70");
    wr(EOI, 31, S);
    setLines('0);

    // R7 / R8 non-secure mask view
    wr(PMASK, 10'h40, S);
    rdChk(PMASK, NS, 8'h00, "R7", "secure-range mask hidden");
    wr(PMASK, 10'h10, NS);
    rdChk(PMASK, S, 8'h40, "R8", "non-secure write ignored");
    wr(PMASK, 10'hC0, S);
    rdChk(PMASK, NS, 8'h80, "R7", "folded read");
    wr(PMASK, 10'h44, NS);
    rdChk(PMASK, S, 8'hA2, "R8", "non-secure write stored");
    rdChk(PMASK, NS, 8'h44, "R7", "folded read back");
    wr(PMASK, 10'hFF, S);

    // R10 common binary point
    wr(CTRL, 1, S);
    rdChk(BINPT, NS, 3, "R10", "common view plus one");
    wr(BINPT, 5, NS);
    rdChk(BINPT, S, 2, "R10", "non-secure write ignored");
    wr(BINPT, 7, S);
    rdChk(BINPT, NS, 7, "R10", "saturated at 7");
    wr(CTRL, 0, S);
    wr(BINPT, 4, NS);
    rdChk(BINPT, NS, 4, "R10", "separate copy written");
    rdChk(BINPT, S, 7, "R10", "secure copy untouched");
    wr(BINPT, 2, S);

    // R11 group-1 uses non-secure binary point plus one
    irqGroup = 32'h0000_0002;
    wr(BINPT, 1, NS);
    setLines(32'h0000_0006);
    rdChk(ACK, S, 1, "R11", "tie goes to id 1");
    wr(EOI, 1, S);
    wr(CTRL, 1, S);
    wr(BINPT, 0, S);
    rdChk(ACK, S, 2, "R11", "common bp picks id 2");
    wr(EOI, 2, S);
    wr(CTRL, 0, S);
    wr(BINPT, 2, S);
    setLines('0);
    irqGroup = '0;

    // R12 reserved addresses and secure-only control
    wr(4'd9, 10'h3FF, S);
    rdChk(4'd9, S, 0, "R12", "reserved reads zero");
    rdChk(PMASK, S, 8'hFF, "R12", "mask unaffected by reserved write");
    wr(CTRL, 1, NS);
    rdChk(CTRL, S, 0, "R12", "non-secure control write ignored");
    wr(CTRL, 1, S);
    rdChk(CTRL, NS, 0, "R12", "control hidden from non-secure");
    rdChk(CTRL, S, 1, "R12", "secure control readback");

    finishRun();
  end
endmodule